// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs the controller side of an I2C transfer as a list of messages, one at a time, on top of a separate byte-level bus engine. Each message names a 7-bit target address, a direction, a byte count and whether it closes with STOP. The sequencer asks the engine for START, repeated START and STOP, hands it the address byte, counts the data bytes the engine reports, and signals completion, a missing target, or an I/O fault. Bit timing on SCL/SDA, data FIFOs and clock generation live in other blocks.

Messages without STOP leave the sequencer parked in a suspend state. The next message continues without a new START if it keeps the same direction. A read that follows a parked write forces a repeated START. Bus faults, a STOP that never completes, and a bus that is found busy at the start of a transfer all lead to a recovery state. In that state the engine is held disabled until SCL and SDA both read high. Millisecond timeouts come from a prescaled tick counter.

Message commands arrive on a valid/ready stream. `cmd_ready` is low only while a command is held waiting for recovery to finish. Any other command that completes a handshake is consumed, even in a state that cannot take it; such a command is answered with a `cmd_reject` pulse and changes nothing. The address byte leaves on its own valid/ready stream. The byte and its value stay stable while `addr_ready` is low.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset `state_o` is 0 (idle), `stop_req` and `addr_valid` are 0, `eng_en` and `cmd_ready` are 1, and every status pulse is 0. State codes: 0 idle, 1 wait-start, 2 wait-restart, 3 write, 4 write-suspend, 5 read, 6 read-suspend, 7 wait-stop, 8 recovery.
- R2: A command taken in idle with `bus_busy` low moves to state 1 on the next edge and pulses `start_req` for one cycle.
- R3: In state 1 or 2, a `start_done` pulse raises `addr_valid` with `addr_data` = {address, read bit}, where bit 0 is 1 for a read. The byte holds stable until `addr_ready`. The accepting edge drops `addr_valid` and enters state 5 for a read or state 3 for a write.
- R4: In state 3 or 5, each `byte_done` counts one data byte. The edge of the last byte, or the next edge for a zero-length message, pulses `msg_done`. With the STOP flag it then sets `stop_req` and enters state 7. Without it, it enters state 4 for a write or state 6 for a read.
- R5: `rd_last` is high exactly while in state 5 with the STOP flag set and one byte left, so the engine NACKs that byte.
- R6: From state 4, a write goes to state 3 with no `start_req` and a read goes to state 2 with a `start_req` pulse. From state 6, a read goes to state 5 with no `start_req`.
- R7: `nack` in states 1, 2, 3 or 5 sets `stop_req`, pulses `err_nodev` and enters state 7.
- R8: `bus_err` in any state other than 0 or 8 pulses `ber_clr` and `err_io`, and enters state 8.
- R9: `stop_done` clears `stop_req`. State 7 returns to 0 once STOP is done. If STOP is not done within STOP_TO_MS ms, the block enters state 8.
- R10: State 8 holds `eng_en` low. Once SCL and SDA both read high, it leaves for state 0, or for state 1 with `start_req` if a command is waiting. If the lines stay low for IDLE_TO_MS ms, it pulses `err_io` and stays parked in state 8.
- R11: A command taken in idle while `bus_busy` is high, or in parked state 8, first runs recovery. `cmd_ready` stays low until recovery finishes.
- R12: A command taken in states 1, 2, 3, 5 or 7, during running recovery, or a write taken in state 6, pulses `cmd_reject` and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cmd_valid | input | 1 | message command valid |
| cmd_ready | output | 1 | command can be taken |
| cmd_read | input | 1 | 1 = read message |
| cmd_stop | input | 1 | message ends with STOP |
| cmd_len | input | LEN_W | data byte count |
| cmd_addr | input | 7 | target address |
| start_req | output | 1 | pulse: issue START / repeated START |
| start_done | input | 1 | pulse: START completed |
| addr_valid | output | 1 | address byte valid |
| addr_ready | input | 1 | engine takes address byte |
| addr_data | output | 8 | address byte with direction bit |
| byte_done | input | 1 | pulse: one data byte moved |
| rd_last | output | 1 | current read byte is the last one before STOP |
| stop_req | output | 1 | STOP request, held until done |
| stop_done | input | 1 | pulse: STOP generated |
| nack | input | 1 | pulse: target did not acknowledge |
| bus_err | input | 1 | pulse: bus error detected |
| ber_clr | output | 1 | pulse: clear engine error flag |
| bus_busy | input | 1 | engine sees the bus busy |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| eng_en | output | 1 | engine enable |
| msg_done | output | 1 | pulse: message complete |
| err_nodev | output | 1 | pulse: no-device error |
| err_io | output | 1 | pulse: I/O error |
| cmd_reject | output | 1 | pulse: command refused |
| state_o | output | 4 | current state code |

## Verification
The hardest condition to reach from the ports is a command that lands in the parked recovery state, or in idle with the bus busy, and must wait behind recovery. The stimulus holds SCL low through a STOP timeout and then a recovery timeout to park the block. It sends a command while the lines are still low, then releases them and checks that the held START follows. Random chains of writes and reads of random lengths, addresses and STOP flags, with random address-byte stalls, cover every suspend transition, including the refused write after a parked read.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_WSTART   = 4'd1,
    ST_WRESTART = 4'd2,
    ST_WR       = 4'd3,
    ST_WSUSP    = 4'd4,
    ST_RD       = 4'd5,
    ST_RSUSP    = 4'd6,
    ST_WSTOP    = 4'd7,
    ST_RECOV    = 4'd8
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int CLK_PER_MS = 125000,
  parameter int MS_W       = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [MS_W-1:0] limit,
  output logic            expired
);
  localparam int DIV_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

  logic [DIV_W-1:0] div_q;
  logic [MS_W-1:0]  ms_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ms_q  <= '0;
    end else if (clr) begin
      div_q <= '0;
      ms_q  <= '0;
    end else if (div_q == DIV_W'(CLK_PER_MS - 1)) begin
      div_q <= '0;
      if (ms_q != {MS_W{1'b1}}) ms_q <= ms_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign expired = (ms_q >= limit);

  // R9/R10: elapsed time never runs backwards unless restarted
  a_r9_time_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ms_q >= $past(ms_q));
endmodule

// File: rtl/i2c_seq_bytecnt.sv
module i2c_seq_bytecnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             zero,
  output logic             one
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rem_q <= '0;
    else if (load)              rem_q <= load_val;
    else if (dec && rem_q != 0) rem_q <= rem_q - 1'b1;
  end

  assign zero = (rem_q == '0);
  assign one  = (rem_q == LEN_W'(1));

  // R4: the count stays at zero when a stray byte arrives
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && dec && !load) |=> zero);
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int MS_W       = 7,
  parameter int STOP_TO_MS = 25,
  parameter int IDLE_TO_MS = 35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_read,
  input  logic            cmd_stop,
  input  logic [6:0]      cmd_addr,
  output logic            start_req,
  input  logic            start_done,
  output logic            addr_valid,
  input  logic            addr_ready,
  output logic [7:0]      addr_data,
  input  logic            byte_done,
  output logic            rd_last,
  output logic            stop_req,
  input  logic            stop_done,
  input  logic            nack,
  input  logic            bus_err,
  output logic            ber_clr,
  input  logic            bus_busy,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            eng_en,
  output logic            msg_done,
  output logic            err_nodev,
  output logic            err_io,
  output logic            cmd_reject,
  output logic [3:0]      state_o,
  output logic            cnt_load,
  output logic            cnt_dec,
  input  logic            cnt_zero,
  input  logic            cnt_one,
  output logic            tmr_clr,
  output logic [MS_W-1:0] tmr_limit,
  input  logic            tmr_expired
);
  seq_state_e st_q, st_d;
  logic pend_q, pend_d, rec_q, rec_d, stop_q, stop_d, avld_q, avld_d;
  logic rd_q, rd_d, stp_q, stp_d;
  logic [6:0] addr_q, addr_d;
  logic start_q, start_d, done_q, done_d, nodev_q, nodev_d;
  logic io_q, io_d, rej_q, rej_d, bclr_q, bclr_d;
  logic fire, took, active, fifo_st, fin, lines_ok;

  assign cmd_ready = !pend_q;
  assign fire      = cmd_valid && cmd_ready;
  assign active    = (st_q == ST_WSTART) || (st_q == ST_WRESTART) ||
                     (st_q == ST_WR) || (st_q == ST_RD);
  assign fifo_st   = (st_q == ST_WR) || (st_q == ST_RD);
  assign cnt_dec   = byte_done && fifo_st;
  assign fin       = cnt_zero || (cnt_one && byte_done);
  assign lines_ok  = scl_in && sda_in;

  always_comb begin
    st_d = st_q; pend_d = pend_q; rec_d = rec_q; stop_d = stop_q;
    avld_d = avld_q; rd_d = rd_q; stp_d = stp_q; addr_d = addr_q;
    start_d = 1'b0; done_d = 1'b0; nodev_d = 1'b0; io_d = 1'b0; bclr_d = 1'b0;
    took = 1'b0;
    if (stop_done) stop_d = 1'b0;
    if (bus_err && st_q != ST_IDLE && st_q != ST_RECOV) begin
      stop_d = 1'b1; bclr_d = 1'b1; io_d = 1'b1;
      st_d = ST_RECOV; rec_d = 1'b1; avld_d = 1'b0;
    end else if (nack && active) begin
      stop_d = 1'b1; nodev_d = 1'b1; st_d = ST_WSTOP; avld_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (fire) begin
          took = 1'b1;
          if (bus_busy) begin
            st_d = ST_RECOV; rec_d = 1'b1; pend_d = 1'b1;
          end else begin
            st_d = ST_WSTART; start_d = 1'b1;
          end
        end
        ST_RECOV: begin
          stop_d = 1'b0;
          if (rec_q) begin
            if (lines_ok) begin
              rec_d = 1'b0; pend_d = 1'b0;
              if (pend_q) begin
                st_d = ST_WSTART; start_d = 1'b1;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (tmr_expired) begin
              rec_d = 1'b0; pend_d = 1'b0; io_d = 1'b1;
            end
          end else if (fire) begin
            took = 1'b1; rec_d = 1'b1; pend_d = 1'b1;
          end
        end
        ST_WSTART, ST_WRESTART: begin
          if (avld_q && addr_ready) begin
            avld_d = 1'b0;
            st_d = rd_q ? ST_RD : ST_WR;
          end else if (start_done && !avld_q) begin
            avld_d = 1'b1;
          end
        end
        ST_WR, ST_RD: if (fin) begin
          done_d = 1'b1;
          if (stp_q) begin
            stop_d = 1'b1; st_d = ST_WSTOP;
          end else begin
            st_d = rd_q ? ST_RSUSP : ST_WSUSP;
          end
        end
        ST_WSUSP: if (fire) begin
          took = 1'b1;
          if (cmd_read) begin
            st_d = ST_WRESTART; start_d = 1'b1;
          end else begin
            st_d = ST_WR;
          end
        end
        ST_RSUSP: if (fire && cmd_read) begin
          took = 1'b1; st_d = ST_RD;
        end
        ST_WSTOP: begin
          if (!stop_q || stop_done) st_d = ST_IDLE;
          else if (tmr_expired) begin
            st_d = ST_RECOV; rec_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (took) begin
      addr_d = cmd_addr; rd_d = cmd_read; stp_d = cmd_stop;
    end
    rej_d    = fire && !took;
    cnt_load = took;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; pend_q <= 1'b0; rec_q <= 1'b0; stop_q <= 1'b0;
      avld_q <= 1'b0; rd_q <= 1'b0; stp_q <= 1'b0; addr_q <= '0;
      start_q <= 1'b0; done_q <= 1'b0; nodev_q <= 1'b0;
      io_q <= 1'b0; rej_q <= 1'b0; bclr_q <= 1'b0;
    end else begin
      st_q <= st_d; pend_q <= pend_d; rec_q <= rec_d; stop_q <= stop_d;
      avld_q <= avld_d; rd_q <= rd_d; stp_q <= stp_d; addr_q <= addr_d;
      start_q <= start_d; done_q <= done_d; nodev_q <= nodev_d;
      io_q <= io_d; rej_q <= rej_d; bclr_q <= bclr_d;
    end
  end

  assign tmr_clr    = (st_d != st_q) || (rec_d != rec_q);
  assign tmr_limit  = (st_q == ST_WSTOP) ? MS_W'(STOP_TO_MS) : MS_W'(IDLE_TO_MS);
  assign start_req  = start_q;
  assign addr_valid = avld_q;
  assign addr_data  = {addr_q, rd_q};
  assign rd_last    = (st_q == ST_RD) && stp_q && cnt_one;
  assign stop_req   = stop_q;
  assign ber_clr    = bclr_q;
  assign eng_en     = (st_q != ST_RECOV);
  assign msg_done   = done_q;
  assign err_nodev  = nodev_q;
  assign err_io     = io_q;
  assign cmd_reject = rej_q;
  assign state_o    = st_q;

  // R3: the address byte stays put while the engine stalls
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (avld_q && !addr_ready && !nack && !bus_err) |=> (avld_q && $stable(addr_data)));
  // R6: a write chained after a parked write needs no START
  a_r6_chain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WSUSP && fire && !cmd_read && !bus_err) |=> (st_q == ST_WR && !start_req));
  // R7: target NACK ends the transfer with STOP
  a_r7_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && !bus_err && active) |=> (st_q == ST_WSTOP && stop_req && err_nodev));
  // R8: bus error enters recovery with the engine off
  a_r8_bus_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && st_q != ST_IDLE && st_q != ST_RECOV) |=> (st_q == ST_RECOV && err_io && ber_clr && !eng_en));
  // R9: a finished STOP returns to idle
  a_r9_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WSTOP && !stop_req && !bus_err) |=> st_q == ST_IDLE);
  // R12: commands during an active message are refused
  a_r12_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (active || st_q == ST_WSTOP)) |=> cmd_reject);
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq #(
  parameter int CLK_PER_MS = 125000,
  parameter int STOP_TO_MS = 25,
  parameter int IDLE_TO_MS = 35,
  parameter int LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_read,
  input  logic             cmd_stop,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [6:0]       cmd_addr,
  output logic             start_req,
  input  logic             start_done,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [7:0]       addr_data,
  input  logic             byte_done,
  output logic             rd_last,
  output logic             stop_req,
  input  logic             stop_done,
  input  logic             nack,
  input  logic             bus_err,
  output logic             ber_clr,
  input  logic             bus_busy,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             eng_en,
  output logic             msg_done,
  output logic             err_nodev,
  output logic             err_io,
  output logic             cmd_reject,
  output logic [3:0]       state_o
);
  localparam int MAX_MS = (STOP_TO_MS > IDLE_TO_MS) ? STOP_TO_MS : IDLE_TO_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1) + 1;

  logic cnt_load, cnt_dec, cnt_zero, cnt_one;
  logic tmr_clr, tmr_expired;
  logic [MS_W-1:0] tmr_limit;

  i2c_seq_bytecnt #(.LEN_W(LEN_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cmd_len),
    .dec(cnt_dec), .zero(cnt_zero), .one(cnt_one)
  );

  i2c_seq_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) i_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit),
    .expired(tmr_expired)
  );

  i2c_seq_fsm #(.MS_W(MS_W), .STOP_TO_MS(STOP_TO_MS), .IDLE_TO_MS(IDLE_TO_MS)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_stop(cmd_stop), .cmd_addr(cmd_addr),
    .start_req(start_req), .start_done(start_done),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
    .byte_done(byte_done), .rd_last(rd_last),
    .stop_req(stop_req), .stop_done(stop_done),
    .nack(nack), .bus_err(bus_err), .ber_clr(ber_clr),
    .bus_busy(bus_busy), .scl_in(scl_in), .sda_in(sda_in), .eng_en(eng_en),
    .msg_done(msg_done), .err_nodev(err_nodev), .err_io(err_io),
    .cmd_reject(cmd_reject), .state_o(state_o),
    .cnt_load(cnt_load), .cnt_dec(cnt_dec), .cnt_zero(cnt_zero), .cnt_one(cnt_one),
    .tmr_clr(tmr_clr), .tmr_limit(tmr_limit), .tmr_expired(tmr_expired)
  );
endmodule

// File: tb/test_i2c_msg_seq.sv
module test_i2c_msg_seq;
  localparam int LEN_W = 8;
  localparam int CPM   = 4;
  localparam int STO   = 25;
  localparam int ITO   = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_read = 0, cmd_stop = 0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [6:0] cmd_addr = '0;
  logic start_done = 0, addr_ready = 0, byte_done = 0, stop_done = 0;
  logic nack = 0, bus_err = 0, bus_busy = 0, scl_in = 1, sda_in = 1;
  logic cmd_ready, start_req, addr_valid, rd_last, stop_req, ber_clr, eng_en;
  logic msg_done, err_nodev, err_io, cmd_reject;
  logic [7:0] addr_data;
  logic [3:0] state_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_msg_seq #(.CLK_PER_MS(CPM), .STOP_TO_MS(STO), .IDLE_TO_MS(ITO), .LEN_W(LEN_W)) i_i2c_msg_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_stop(cmd_stop), .cmd_len(cmd_len), .cmd_addr(cmd_addr),
    .start_req(start_req), .start_done(start_done), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_data(addr_data), .byte_done(byte_done),
    .rd_last(rd_last), .stop_req(stop_req), .stop_done(stop_done), .nack(nack),
    .bus_err(bus_err), .ber_clr(ber_clr), .bus_busy(bus_busy), .scl_in(scl_in),
    .sda_in(sda_in), .eng_en(eng_en), .msg_done(msg_done), .err_nodev(err_nodev),
    .err_io(err_io), .cmd_reject(cmd_reject), .state_o(state_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int suspend_code(bit rd);
    return rd ? 6 : 4;
  endfunction

  function automatic int end_code(bit rd, bit stp);
    return stp ? 7 : suspend_code(rd);
  endfunction

  function automatic int after_cmd(int st, bit rd);
    if (st == 0) return 1;
    if (st == 4) return rd ? 2 : 3;
    if (st == 6 && rd) return 5;
    return st;
  endfunction

  task automatic send_cmd(bit rd, int len, bit stp, logic [6:0] a);
    cmd_valid = 1; cmd_read = rd; cmd_len = LEN_W'(len); cmd_stop = stp; cmd_addr = a;
    cyc();
    cmd_valid = 0;
  endtask

  task automatic addr_phase(bit rd, logic [6:0] a, int stall);
    start_done = 1; cyc(); start_done = 0;
    check("R3 addr_valid", int'(addr_valid), 1);
    check("R3 addr_data", int'(addr_data), int'({a, rd}));
    for (int k = 0; k < stall; k++) begin
      cyc();
      check("R3 stall hold", int'(addr_data), int'({a, rd}));
    end
    addr_ready = 1; cyc(); addr_ready = 0;
    check("R3 fifo state", int'(state_o), rd ? 5 : 3);
    check("R3 addr_valid drop", int'(addr_valid), 0);
  endtask

  task automatic data_phase(bit rd, int len, bit stp);
    if (len == 0) begin
      cyc();
    end else begin
      for (int i = 0; i < len; i++) begin
        check("R5 rd_last", int'(rd_last), (rd && stp && (len - i) == 1) ? 1 : 0);
        byte_done = 1; cyc(); byte_done = 0;
        if (i < len - 1) begin
          check("R4 mid msg_done", int'(msg_done), 0);
          if ($urandom_range(0, 1) == 1) cyc();
        end
      end
    end
    check("R4 msg_done", int'(msg_done), 1);
    check("R4 end state", int'(state_o), end_code(rd, stp));
    check("R4 stop_req", int'(stop_req), int'(stp));
  endtask

  task automatic stop_phase();
    stop_done = 1; cyc(); stop_done = 0;
    check("R9 stop idle", int'(state_o), 0);
    check("R9 stop cleared", int'(stop_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int st;
    int n;
    void'($urandom(32'h1c2a5eed));
    cyc(); cyc();
    rst_n = 1;
    cyc();
    // R1
    check("R1 state", int'(state_o), 0);
    check("R1 stop_req", int'(stop_req), 0);
    check("R1 eng_en", int'(eng_en), 1);
    check("R1 addr_valid", int'(addr_valid), 0);
    check("R1 cmd_ready", int'(cmd_ready), 1);
    check("R1 pulses", int'({msg_done, err_nodev, err_io, cmd_reject, start_req, ber_clr}), 0);

    // R2 + R12: write, reject while writing
    send_cmd(0, 3, 1, 7'h2a);
    check("R2 wait start", int'(state_o), 1);
    check("R2 start_req", int'(start_req), 1);
    send_cmd(1, 1, 1, 7'h11);
    check("R12 reject in wait-start", int'(cmd_reject), 1);
    check("R12 state kept", int'(state_o), 1);
    addr_phase(0, 7'h2a, 2);
    send_cmd(1, 1, 1, 7'h11);
    check("R12 reject in write", int'(cmd_reject), 1);
    check("R12 write kept", int'(state_o), 3);
    data_phase(0, 3, 1);
    stop_phase();

    // R7 NACK during write
    send_cmd(0, 2, 1, 7'h50);
    addr_phase(0, 7'h50, 0);
    nack = 1; cyc(); nack = 0;
    check("R7 state", int'(state_o), 7);
    check("R7 stop_req", int'(stop_req), 1);
    check("R7 err_nodev", int'(err_nodev), 1);
    stop_phase();

    // R8 bus error in wait-start, recovery exits on high lines
    send_cmd(1, 1, 1, 7'h33);
    bus_err = 1; cyc(); bus_err = 0;
    check("R8 state", int'(state_o), 8);
    check("R8 err_io", int'(err_io), 1);
    check("R8 ber_clr", int'(ber_clr), 1);
    check("R8 eng_en", int'(eng_en), 0);
    cyc();
    check("R10 recover idle", int'(state_o), 0);
    check("R10 eng_en back", int'(eng_en), 1);

    // R9 STOP timeout, then R10 recovery timeout with SCL low
    send_cmd(0, 0, 1, 7'h05);
    addr_phase(0, 7'h05, 0);
    data_phase(0, 0, 1);
    scl_in = 0;
    n = 0;
    while (state_o == 4'd7 && n < 400) begin cyc(); n++; end
    check("R9 stop timeout state", int'(state_o), 8);
    check("R9 stop timeout window", int'(n >= STO * CPM - 4 && n <= STO * CPM + 4), 1);
    check("R10 eng_en off", int'(eng_en), 0);
    n = 0;
    while (!err_io && n < 400) begin cyc(); n++; end
    check("R10 idle timeout err_io", int'(err_io), 1);
    check("R10 idle timeout window", int'(n >= ITO * CPM - 4 && n <= ITO * CPM + 4), 1);
    cyc();
    check("R10 parked", int'(state_o), 8);

    // R11 command in parked recovery waits for the lines
    send_cmd(0, 1, 1, 7'h44);
    check("R11 held in recovery", int'(state_o), 8);
    check("R11 cmd_ready low", int'(cmd_ready), 0);
    scl_in = 1; cyc();
    check("R11 start after recovery", int'(state_o), 1);
    check("R11 start_req", int'(start_req), 1);
    check("R11 cmd_ready back", int'(cmd_ready), 1);
    addr_phase(0, 7'h44, 0);
    data_phase(0, 1, 1);
    stop_phase();

    // R11 busy bus at transfer start
    bus_busy = 1;
    send_cmd(1, 2, 1, 7'h21);
    bus_busy = 0;
    check("R11 busy recovery", int'(state_o), 8);
    cyc();
    check("R11 busy then start", int'(state_o), 1);
    addr_phase(1, 7'h21, 1);
    data_phase(1, 2, 1);
    stop_phase();

    // R4/R5/R6/R12 random message chains
    st = 0;
    for (int it = 0; it < 80; it++) begin
      bit rd = 1'($urandom_range(0, 1));
      bit stp = ($urandom_range(0, 2) == 0);
      int len = $urandom_range(0, 5);
      logic [6:0] a = 7'($urandom);
      if (st == 6 && !rd) begin
        send_cmd(0, len, stp, a);
        check("R12 write after read refused", int'(cmd_reject), 1);
        check("R12 read-suspend kept", int'(state_o), 6);
        continue;
      end
      send_cmd(rd, len, stp, a);
      check("R6 state after command", int'(state_o), after_cmd(st, rd));
      check("R6 start_req", int'(start_req), (after_cmd(st, rd) <= 2) ? 1 : 0);
      if (after_cmd(st, rd) <= 2) addr_phase(rd, a, $urandom_range(0, 2));
      data_phase(rd, len, stp);
      if (stp) begin
        stop_phase();
        st = 0;
      end else begin
        st = suspend_code(rd);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule